// File: doc/BRIEF.md
# Serial Receive Buffer with Automatic Request-to-Send

This block takes an asynchronous serial line, frames 8N1 characters out of it using a 16x oversampling enable, and queues the received bytes in a 16-entry first-in first-out store that a host drains one byte per read strobe. It also drives an active-low request-to-send line, so that the remote sender pauses before the store can overflow.

For the three lower thresholds (1, 4 and 8 bytes), the request line is withdrawn once the stored count reaches the threshold. It is raised again once reads bring the count below the threshold. The store still has room, so one more byte that was already in flight is accepted.

At the 14-byte setting the block holds the line active for as long as possible. It withdraws the line only when it samples the first data bit of the sixteenth character. It raises the line again when a slot is free and nothing is arriving, or when two or more slots are free. When the store is full, the first host read raises the line again at once. A byte that arrives while the store is full is dropped and sets a sticky overrun flag, which the next read clears.

Receiver states: `RX_IDLE` (line watched for a falling edge) → `RX_START` (start bit checked at mid-bit, back to `RX_IDLE` if the line is high) → `RX_DATA` (eight bits sampled LSB first, one every 16 ticks) → `RX_STOP` (byte delivered at mid stop bit) → `RX_IDLE`. Flow-control states: `RTS_ON` (line driven low) ⇄ `RTS_OFF` (line driven high). The transitions depend on the threshold, as described above.

Top module: `rx_flow_ctrl`

## Requirements
- R1: After reset, rts_n is 0, data_rdy is 0, fifo_full is 0 and ovr_flag is 0.
- R2: A frame is one low start bit, eight data bits sent LSB first and one high stop bit, each 16 ticks long. Received bytes appear on rd_data in arrival order. data_rdy is 1 while the store is not empty, and a one-cycle rd_stb removes the front byte.
- R3: A low pulse on rx_line that ends before the mid-bit check of the start bit (8 ticks) is ignored and stores nothing.
- R4: trig_sel selects the threshold: 00 = 1, 01 = 4, 10 = 8, 11 = 14 bytes. For 00, 01 and 10, rts_n goes to 1 once the stored count is at least the threshold.
- R5: A byte that arrives after rts_n has gone to 1 is stored, provided the store is not full.
- R6: For thresholds 1, 4 and 8, rts_n returns to 0 once the stored count drops below the threshold.
- R7: For threshold 14, rts_n stays 0 while 15 bytes are held and during the start bit of the sixteenth byte. It goes to 1 after the first data bit of that byte has been sampled.
- R8: fifo_full is 1 exactly when 16 bytes are held, and the count never exceeds 16.
- R9: For threshold 14, rts_n returns to 0 when one slot is free and no frame is in progress, or when more than one slot is free. A read while full returns rts_n to 0 in the next cycle, even if a frame is in progress.
- R10: A byte that completes while the store is full is discarded and sets ovr_flag. ovr_flag stays set until an rd_stb, after which it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_line | input | 1 | Serial receive line, idle high |
| tick16 | input | 1 | Enable pulse at 16 times the bit rate |
| rd_stb | input | 1 | One-cycle host read of the front byte |
| trig_sel | input | 2 | Threshold select (00=1, 01=4, 10=8, 11=14) |
| rd_data | output | 8 | Front byte of the store |
| data_rdy | output | 1 | Store holds at least one byte |
| ovr_flag | output | 1 | Sticky overrun indication |
| rts_n | output | 1 | Active-low request-to-send |
| fifo_full | output | 1 | Store holds 16 bytes |

## Verification
For the thresholds 1, 4 and 8, the bench sends bursts that stop one byte short of the threshold, reach it exactly and then go one byte past it. This separates an off-by-one in the release comparison from a lost in-flight byte. At the top threshold it probes the request line during the start bit and again after the first data bit of the sixteenth character, which tells the mid-frame release apart from a release at a byte boundary.

Two reads from a full store are made: one while the line is idle and one while a character is mid-frame. The second shows whether the read-when-full rule overrides the busy condition. A short low glitch and a byte sent into a full store check start validation and the sticky overrun flag against the in-order data that the scoreboard expects.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;

    typedef enum logic [1:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_t;

    typedef enum logic {
        RTS_ON,
        RTS_OFF
    } rts_state_t;

    localparam int unsigned LVL_A = 1;
    localparam int unsigned LVL_B = 4;
    localparam int unsigned LVL_C = 8;
    localparam int unsigned LVL_TOP = 14;

endpackage

// File: rtl/rxfc_deser.sv
module rxfc_deser
    import rxfc_pkg::*;
#(
    parameter int unsigned DW  = 8,
    parameter int unsigned OSR = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_line,
    input  logic          tick,
    output logic          byte_vld,
    output logic [DW-1:0] byte_out,
    output logic          first_bit,
    output logic          busy
);
    localparam int unsigned CW  = $clog2(OSR);
    localparam int unsigned BW  = (DW > 1) ? $clog2(DW) : 1;
    localparam logic [CW-1:0] MID  = CW'(OSR / 2 - 1);
    localparam logic [CW-1:0] LAST = CW'(OSR - 1);
    localparam logic [BW-1:0] TOPB = BW'(DW - 1);

    rx_state_t     state, nxt;
    logic          rx_s;
    logic          rx_prev;
    logic [CW-1:0] tcnt;
    logic [BW-1:0] bidx;
    logic [DW-1:0] shreg;

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:  if (tick && rx_prev && !rx_s) nxt = RX_START;
            RX_START: if (tick && tcnt == MID) nxt = rx_s ? RX_IDLE : RX_DATA;
            RX_DATA:  if (tick && tcnt == LAST && bidx == TOPB) nxt = RX_STOP;
            RX_STOP:  if (tick && tcnt == LAST) nxt = RX_IDLE;
            default:  nxt = RX_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= RX_IDLE;
        else        state <= nxt;
    end

    // datapath and output pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_s      <= 1'b1;
            rx_prev   <= 1'b1;
            tcnt      <= '0;
            bidx      <= '0;
            shreg     <= '0;
            byte_out  <= '0;
            byte_vld  <= 1'b0;
            first_bit <= 1'b0;
        end else begin
            rx_s      <= rx_line;
            byte_vld  <= 1'b0;
            first_bit <= 1'b0;
            if (tick) begin
                rx_prev <= rx_s;
                unique case (state)
                    RX_IDLE: begin
                        tcnt <= '0;
                        bidx <= '0;
                    end
                    RX_START: begin
                        tcnt <= (tcnt == MID) ? '0 : tcnt + 1'b1;
                    end
                    RX_DATA: begin
                        if (tcnt == LAST) begin
                            tcnt      <= '0;
                            shreg     <= {rx_s, shreg[DW-1:1]};
                            bidx      <= bidx + 1'b1;
                            first_bit <= (bidx == '0);
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    RX_STOP: begin
                        if (tcnt == LAST) begin
                            tcnt     <= '0;
                            byte_vld <= 1'b1;
                            byte_out <= shreg;
                        end else begin
                            tcnt <= tcnt + 1'b1;
                        end
                    end
                    default: tcnt <= '0;
                endcase
            end
        end
    end

    always_comb busy = (state != RX_IDLE);

endmodule

// File: rtl/rxfc_fifo.sv
module rxfc_fifo #(
    parameter int unsigned DW    = 8,
    parameter int unsigned DEPTH = 16,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned CNTW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [DW-1:0]   wdata,
    input  logic            pop,
    output logic [DW-1:0]   rdata,
    output logic [CNTW-1:0] count,
    output logic            full,
    output logic            ovr
);
    localparam logic [CNTW-1:0] DEPTH_C = CNTW'(DEPTH);
    localparam logic [AW-1:0]   LASTP   = AW'(DEPTH - 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          pop_ok, acc, drop;

    always_comb begin
        pop_ok = pop && (count != '0);
        acc    = push && ((count != DEPTH_C) || pop_ok);
        drop   = push && !acc;
        full   = (count == DEPTH_C);
        rdata  = mem[rp];
    end

    always_ff @(posedge clk) begin
        if (acc) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
            ovr   <= 1'b0;
        end else begin
            if (acc)    wp <= (wp == LASTP) ? '0 : wp + 1'b1;
            if (pop_ok) rp <= (rp == LASTP) ? '0 : rp + 1'b1;
            if (acc && !pop_ok)      count <= count + 1'b1;
            else if (!acc && pop_ok) count <= count - 1'b1;
            if (pop)       ovr <= 1'b0;
            else if (drop) ovr <= 1'b1;
        end
    end

endmodule

// File: rtl/rxfc_rts.sv
module rxfc_rts
    import rxfc_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CNTW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [1:0]      trig_sel,
    input  logic [CNTW-1:0] count,
    input  logic            busy,
    input  logic            first_bit,
    input  logic            rd_stb,
    output logic            rts_n
);
    localparam logic [CNTW-1:0] DEPTH_C = CNTW'(DEPTH);
    localparam logic [CNTW-1:0] NEAR_C  = CNTW'(DEPTH - 1);

    rts_state_t      state, nxt;
    logic [CNTW-1:0] lvl;
    logic [CNTW-1:0] free;
    logic            top;

    always_comb begin
        unique case (trig_sel)
            2'b00:   lvl = CNTW'(LVL_A);
            2'b01:   lvl = CNTW'(LVL_B);
            2'b10:   lvl = CNTW'(LVL_C);
            default: lvl = CNTW'(LVL_TOP);
        endcase
        top  = (trig_sel == 2'b11);
        free = DEPTH_C - count;
    end

    // next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            RTS_ON: begin
                if (top) begin
                    if ((first_bit && count == NEAR_C) ||
                        (count == DEPTH_C && !rd_stb))
                        nxt = RTS_OFF;
                end else if (count >= lvl) begin
                    nxt = RTS_OFF;
                end
            end
            RTS_OFF: begin
                if (top) begin
                    if ((rd_stb && count == DEPTH_C) || (free > 1) ||
                        (free >= 1 && !busy))
                        nxt = RTS_ON;
                end else if (count < lvl) begin
                    nxt = RTS_ON;
                end
            end
            default: nxt = RTS_ON;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= RTS_ON;
        else        state <= nxt;
    end

    // output decode
    always_comb rts_n = (state == RTS_OFF);

endmodule

// File: rtl/rx_flow_ctrl.sv
module rx_flow_ctrl #(
    parameter int unsigned DW    = 8,
    parameter int unsigned DEPTH = 16,
    parameter int unsigned OSR   = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_line,
    input  logic          tick16,
    input  logic          rd_stb,
    input  logic [1:0]    trig_sel,
    output logic [DW-1:0] rd_data,
    output logic          data_rdy,
    output logic          ovr_flag,
    output logic          rts_n,
    output logic          fifo_full
);
    localparam int unsigned CNTW = $clog2(DEPTH + 1);

    logic            byte_vld;
    logic [DW-1:0]   byte_out;
    logic            first_bit;
    logic            busy;
    logic [CNTW-1:0] fill_cnt;

    rxfc_deser #(.DW(DW), .OSR(OSR)) u_deser (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_line   (rx_line),
        .tick      (tick16),
        .byte_vld  (byte_vld),
        .byte_out  (byte_out),
        .first_bit (first_bit),
        .busy      (busy)
    );

    rxfc_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (byte_vld),
        .wdata (byte_out),
        .pop   (rd_stb),
        .rdata (rd_data),
        .count (fill_cnt),
        .full  (fifo_full),
        .ovr   (ovr_flag)
    );

    rxfc_rts #(.DEPTH(DEPTH)) u_rts (
        .clk       (clk),
        .rst_n     (rst_n),
        .trig_sel  (trig_sel),
        .count     (fill_cnt),
        .busy      (busy),
        .first_bit (first_bit),
        .rd_stb    (rd_stb),
        .rts_n     (rts_n)
    );

    always_comb data_rdy = (fill_cnt != '0);

endmodule

// File: rtl/rx_flow_ctrl_chk.sv
module rx_flow_ctrl_chk #(
    parameter int unsigned DEPTH = 16,
    localparam int unsigned CNTW = $clog2(DEPTH + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic [1:0]      trig_sel,
    input logic            rd_stb,
    input logic            fifo_full,
    input logic            data_rdy,
    input logic            ovr_flag,
    input logic            rts_n,
    input logic [CNTW-1:0] fill
);
    logic [CNTW-1:0] lvl_chk;
    always_comb begin
        case (trig_sel)
            2'b00:   lvl_chk = CNTW'(1);
            2'b01:   lvl_chk = CNTW'(4);
            2'b10:   lvl_chk = CNTW'(8);
            default: lvl_chk = CNTW'(14);
        endcase
    end

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= CNTW'(DEPTH));

    p_full_has_data_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_full |-> data_rdy);

    p_release_at_level_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_sel != 2'b11 && $stable(trig_sel) && fill >= lvl_chk &&
         $past(fill) >= lvl_chk) |-> rts_n);

    p_read_clears_ovr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> !ovr_flag);

    p_read_full_reasserts_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && fifo_full && trig_sel == 2'b11) |=> !rts_n);

endmodule

bind rx_flow_ctrl rx_flow_ctrl_chk #(.DEPTH(16)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_sel  (trig_sel),
    .rd_stb    (rd_stb),
    .fifo_full (fifo_full),
    .data_rdy  (data_rdy),
    .ovr_flag  (ovr_flag),
    .rts_n     (rts_n),
    .fill      (fill_cnt)
);

// File: tb/test_rx_flow_ctrl.sv
`timescale 1ns/1ps
module test_rx_flow_ctrl;
    localparam int BITCLK = 64;
    localparam int DEPTH  = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b1;
    logic       tick16;
    logic       rd_stb = 1'b0;
    logic [1:0] trig_sel = 2'b00;
    logic [7:0] rd_data;
    logic       data_rdy, ovr_flag, rts_n, fifo_full;
    logic [1:0] tdiv = 2'd0;

    int checks = 0;
    int errors = 0;
    int mcount = 0;
    logic [7:0] exp_q[$];

    always #10 clk = ~clk;
    always_ff @(posedge clk) tdiv <= tdiv + 2'd1;
    assign tick16 = (tdiv == 2'd3);

    rx_flow_ctrl i_rx_flow_ctrl (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .tick16(tick16),
        .rd_stb(rd_stb), .trig_sel(trig_sel), .rd_data(rd_data),
        .data_rdy(data_rdy), .ovr_flag(ovr_flag), .rts_n(rts_n),
        .fifo_full(fifo_full)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // driver: serialises one 8N1 frame, updates the scoreboard at its end
    task automatic send_byte(input logic [7:0] b);
        @(negedge clk) rx_line = 1'b0;
        repeat (BITCLK) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx_line = b[i];
            repeat (BITCLK) @(negedge clk);
        end
        rx_line = 1'b1;
        repeat (BITCLK) @(negedge clk);
        if (mcount < DEPTH) begin
            exp_q.push_back(b);
            mcount++;
        end
        repeat (8) @(negedge clk);
    endtask

    // monitor: compares the front byte with the scoreboard, then pops it
    task automatic read_one(input string tag);
        logic [7:0] e;
        @(negedge clk);
        e = exp_q.pop_front();
        mcount--;
        check({tag, " data_rdy"}, int'(data_rdy), 1);
        check({tag, " rd_data"}, int'(rd_data), int'(e));
        rd_stb = 1'b1;
        @(negedge clk) rd_stb = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic drain(input string tag);
        while (exp_q.size() > 0) read_one(tag);
        check({tag, " empty"}, int'(data_rdy), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 reset state
        check("R1 rts_n", int'(rts_n), 0);
        check("R1 data_rdy", int'(data_rdy), 0);
        check("R1 fifo_full", int'(fifo_full), 0);
        check("R1 ovr_flag", int'(ovr_flag), 0);

        // threshold 1
        trig_sel = 2'b00;
        send_byte(8'hA5);
        check("R4 lvl1 release", int'(rts_n), 1);
        send_byte(8'h3C);
        check("R5 lvl1 extra byte", mcount, 2);
        read_one("R2 lvl1");
        check("R6 lvl1 still high", int'(rts_n), 1);
        read_one("R2 lvl1");
        check("R6 lvl1 reassert", int'(rts_n), 0);

        // threshold 4
        trig_sel = 2'b01;
        for (int i = 0; i < 3; i++) send_byte(8'h10 + 8'(i));
        check("R4 lvl4 below", int'(rts_n), 0);
        send_byte(8'h81);
        check("R4 lvl4 release", int'(rts_n), 1);
        send_byte(8'h7E);
        check("R5 lvl4 extra data_rdy", int'(data_rdy), 1);
        read_one("R2 lvl4");
        check("R6 lvl4 at level", int'(rts_n), 1);
        read_one("R2 lvl4");
        check("R6 lvl4 below level", int'(rts_n), 0);
        drain("R2 lvl4");

        // threshold 8
        trig_sel = 2'b10;
        for (int i = 0; i < 7; i++) send_byte(8'hC0 ^ 8'(i * 37));
        check("R4 lvl8 below", int'(rts_n), 0);
        send_byte(8'h55);
        check("R4 lvl8 release", int'(rts_n), 1);
        read_one("R2 lvl8");
        check("R6 lvl8 reassert", int'(rts_n), 0);
        drain("R2 lvl8");

        // R3 false start
        @(negedge clk) rx_line = 1'b0;
        repeat (12) @(negedge clk);
        rx_line = 1'b1;
        repeat (300) @(negedge clk);
        check("R3 glitch ignored", int'(data_rdy), 0);
        send_byte(8'h96);
        drain("R3 after glitch");

        // threshold 14
        trig_sel = 2'b11;
        for (int i = 0; i < 15; i++) send_byte(8'(i * 17 + 3));
        check("R7 15 held rts low", int'(rts_n), 0);
        fork
            send_byte(8'hE1);
            begin
                repeat (70) @(negedge clk);
                check("R7 start bit of 16th", int'(rts_n), 0);
                repeat (70) @(negedge clk);
                check("R7 after first data bit", int'(rts_n), 1);
            end
        join
        check("R8 full at 16", int'(fifo_full), 1);
        read_one("R2 lvl14");
        check("R9 read when full idle", int'(rts_n), 0);
        check("R8 not full at 15", int'(fifo_full), 0);
        send_byte(8'h4B);
        check("R7 refill release", int'(rts_n), 1);
        fork
            send_byte(8'h2D);
            begin
                repeat (200) @(negedge clk);
                read_one("R2 lvl14 busy");
                check("R9 read when full busy", int'(rts_n), 0);
            end
        join
        check("R8 full again", int'(fifo_full), 1);
        check("R9 release at full", int'(rts_n), 1);
        send_byte(8'hF0);
        check("R10 overrun set", int'(ovr_flag), 1);
        repeat (100) @(negedge clk);
        check("R10 overrun sticky", int'(ovr_flag), 1);
        read_one("R10 read");
        check("R10 overrun cleared", int'(ovr_flag), 0);
        read_one("R9 lvl14");
        check("R9 two free", int'(rts_n), 0);
        drain("R10 order kept");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule